// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment:offset pair into a 20-bit physical byte address. It holds four 16-bit segment base registers: code, data, stack and extra. A requester gives an access kind and a 16-bit offset. The access kind chooses a default segment register, and an optional override names a different one. The chosen segment value is shifted left by four bits, which is one hex digit, and the offset is added to it.

Each segment therefore starts on a 16-byte boundary and covers at most 64 KB. Many different segment:offset pairs point at the same byte. A carry out of the top address bit is dropped, so addresses wrap inside the 1 MB space.

Software loads the segment registers through a synchronous write port with a register select. The address leaves the block through a register. It is valid for one cycle, one cycle after the request strobe.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset `physAddr` is 0, `addrValid` is 0 and all four segment registers hold 0, so a request made before any write returns its offset unchanged.
- R2: The result is the selected 16-bit segment value multiplied by 16 plus the 16-bit offset. Examples: 0FE6h:012Bh gives 0FF8Bh, 2500h:95F3h gives 2E5F3h, and 2567h:2341h gives 279B1h. The pairs 1234h:4321h and 1665h:0011h both give 16661h.
- R3: A carry out of bit 19 is dropped: FFFFh:FFFFh gives 0FFEFh.
- R4: Without an override, `accKind` picks the default segment register. 0 (instruction fetch) uses code, 1 (stack access) uses stack, 2 (source data) uses data, and 3 (destination data) uses extra.
- R5: When `ovrEn` is 1, the register named by `ovrSel` is used in place of the default. The encoding is the same as for `wrSel`.
- R6: When `wrEn` is 1, the register named by `wrSel` takes `wrData` at the next rising edge and no other register changes. The encoding is 0 code, 1 data, 2 stack, 3 extra.
- R7: A request in the same cycle as a write to its own segment register uses the value held before that write.
- R8: `addrValid` is 1 exactly in the cycle after a cycle with `reqValid` 1. The low four bits of `physAddr` then equal the offset of that request. With no request, `physAddr` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Segment register write strobe |
| wrSel | input | 2 | Segment register to write |
| wrData | input | 16 | Value to write |
| reqValid | input | 1 | Address request strobe |
| accKind | input | 2 | Access kind, picks the default segment |
| ovrEn | input | 1 | Use `ovrSel` instead of the default |
| ovrSel | input | 2 | Override segment register |
| offset | input | 16 | Offset within the segment |
| physAddr | output | 20 | Registered physical address |
| addrValid | output | 1 | `physAddr` holds a fresh result |

## Verification
The assertions check on every cycle that `addrValid` follows the request strobe by exactly one cycle. They also check that the low nibble of the result is the request's offset nibble, because the segment contributes zeros there, and that the address holds between requests. The arithmetic, the default pairings, the override, the wrap at 1 MB and the read-before-write ordering of a write and a request in the same cycle depend on loaded segment values. Only the bench's scenarios show these, by checking each result against addresses computed from the requirements.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  // Segment register encoding, shared by the write select and the override select
  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } segSel_t;

  // Access kinds that choose a default segment
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_STACK = 2'd1,
    ACC_SRC   = 2'd2,
    ACC_DST   = 2'd3
  } accKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic    segWrEn;
    segSel_t segWrSel;
    logic    reqTake;
    segSel_t segPick;
  } ctrlStrb_t;

endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import seg_addr_pkg::*;
(
  input  logic      wrEn,
  input  logic [1:0] wrSel,
  input  logic      reqValid,
  input  logic [1:0] accKind,
  input  logic      ovrEn,
  input  logic [1:0] ovrSel,
  output ctrlStrb_t strb
);

  segSel_t defaultSeg;

  // Default segment for each access kind
  always_comb begin
    unique case (accKind_t'(accKind))
      ACC_FETCH: defaultSeg = SEG_CODE;
      ACC_STACK: defaultSeg = SEG_STACK;
      ACC_SRC:   defaultSeg = SEG_DATA;
      ACC_DST:   defaultSeg = SEG_EXTRA;
      default:   defaultSeg = SEG_CODE;
    endcase
  end

  always_comb begin
    strb.segWrEn  = wrEn;
    strb.segWrSel = segSel_t'(wrSel);
    strb.reqTake  = reqValid;
    strb.segPick  = ovrEn ? segSel_t'(ovrSel) : defaultSeg;
  end

endmodule

// File: rtl/seg_addr_dp.sv
module seg_addr_dp
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrb_t               strb,
  input  logic [SEG_W-1:0]        wrData,
  input  logic [OFF_W-1:0]        offset,
  output logic [SEG_W+SHIFT-1:0]  physAddr,
  output logic                    addrValid
);

  localparam int ADDR_W = SEG_W + SHIFT;
  localparam int NSEG   = 4;

  logic [SEG_W-1:0]  segReg [NSEG];
  logic [SEG_W-1:0]  segVal;
  logic [ADDR_W-1:0] baseExt;
  logic [ADDR_W-1:0] offExt;
  logic [ADDR_W-1:0] sumAddr;

  // One register per segment; only the selected one loads
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        segReg[g] <= '0;
      end else if (strb.segWrEn && (strb.segWrSel == segSel_t'(g))) begin
        segReg[g] <= wrData;
      end
    end
  end

  // Segment times 16 plus offset, truncated to the address width (wraps)
  always_comb begin
    segVal  = segReg[strb.segPick];
    baseExt = {segVal, {SHIFT{1'b0}}};
    offExt  = ADDR_W'(offset);
    sumAddr = baseExt + offExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      physAddr  <= '0;
      addrValid <= 1'b0;
    end else begin
      addrValid <= strb.reqTake;
      if (strb.reqTake) begin
        physAddr <= sumAddr;
      end
    end
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [1:0]             wrSel,
  input  logic [SEG_W-1:0]       wrData,
  input  logic                   reqValid,
  input  logic [1:0]             accKind,
  input  logic                   ovrEn,
  input  logic [1:0]             ovrSel,
  input  logic [OFF_W-1:0]       offset,
  output logic [SEG_W+SHIFT-1:0] physAddr,
  output logic                   addrValid
);

  ctrlStrb_t strb;

  seg_addr_ctrl i_ctrl (
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .reqValid (reqValid),
    .accKind  (accKind),
    .ovrEn    (ovrEn),
    .ovrSel   (ovrSel),
    .strb     (strb)
  );

  seg_addr_dp #(
    .SEG_W (SEG_W),
    .OFF_W (OFF_W),
    .SHIFT (SHIFT)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .offset    (offset),
    .physAddr  (physAddr),
    .addrValid (addrValid)
  );

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [OFF_W-1:0]  offset,
  input logic              addrValid,
  input logic [ADDR_W-1:0] physAddr
);

  // R8
  valid_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> addrValid);

  // R8
  no_valid_without_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !addrValid);

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(physAddr));

  // R2
  low_nibble_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (physAddr[3:0] == $past(offset[3:0])));

endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .OFF_W  (OFF_W),
  .ADDR_W (SEG_W + SHIFT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .offset    (offset),
  .addrValid (addrValid),
  .physAddr  (physAddr)
);

// File: tb/test_seg_addr_gen.sv
`timescale 1ns/1ps
module test_seg_addr_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [15:0] wrData = '0;
  logic        reqValid = 1'b0;
  logic [1:0]  accKind = '0;
  logic        ovrEn = 1'b0;
  logic [1:0]  ovrSel = '0;
  logic [15:0] offset = '0;
  logic [19:0] physAddr;
  logic        addrValid;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  logic [19:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;  // 250 MHz

  seg_addr_gen i_seg_addr_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .reqValid(reqValid), .accKind(accKind), .ovrEn(ovrEn), .ovrSel(ovrSel),
    .offset(offset), .physAddr(physAddr), .addrValid(addrValid)
  );

  function automatic logic [19:0] calcAddr(input logic [15:0] s, input logic [15:0] o);
    logic [20:0] full;
    full = {1'b0, s, 4'h0} + {5'h0, o};
    return full[19:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrSeg(input logic [1:0] sel, input logic [15:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Driver: drives one request cycle and pushes the expected result
  task automatic doReq(input logic [1:0] kind, input logic ov, input logic [1:0] osel,
                       input logic [15:0] off, input logic [19:0] exp, input string tag);
    reqValid = 1'b1; accKind = kind; ovrEn = ov; ovrSel = osel; offset = off;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    reqValid = 1'b0; ovrEn = 1'b0;
  endtask

  // Monitor: pops and compares each result as it appears
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && addrValid) begin
        if (expQ.size() == 0) begin
          nCmp++; nBad++;
          $display("FAIL R8: addrValid with no request, actual %h expected none", physAddr);
        end else begin
          logic [19:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(t, 32'(physAddr), 32'(e));
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [19:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset physAddr", 32'(physAddr), 32'h0);
    check("R1 reset addrValid", 32'(addrValid), 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: all segments zero after reset
    doReq(2'd0, 1'b0, 2'd0, 16'h1234, 20'h01234, "R1 code zero");
    doReq(2'd1, 1'b0, 2'd0, 16'hBEEF, 20'h0BEEF, "R1 stack zero");
    doReq(2'd2, 1'b0, 2'd0, 16'h0007, 20'h00007, "R1 data zero");
    doReq(2'd3, 1'b0, 2'd0, 16'hFFFF, 20'h0FFFF, "R1 extra zero");

    // R2, R4: arithmetic with default pairings
    wrSeg(2'd0, 16'h0FE6);
    doReq(2'd0, 1'b0, 2'd0, 16'h012B, 20'h0FF8B, "R2 fetch 0FE6:012B");
    wrSeg(2'd0, 16'h2500);
    doReq(2'd0, 1'b0, 2'd0, 16'h95F3, 20'h2E5F3, "R2 fetch 2500:95F3");
    wrSeg(2'd1, 16'h1234);
    wrSeg(2'd3, 16'h1665);
    wrSeg(2'd2, 16'h2567);
    doReq(2'd2, 1'b0, 2'd0, 16'h4321, 20'h16661, "R4 source uses data");
    doReq(2'd3, 1'b0, 2'd0, 16'h0011, 20'h16661, "R4 dest uses extra alias");
    doReq(2'd1, 1'b0, 2'd0, 16'h2341, 20'h279B1, "R4 stack uses stack");
    doReq(2'd0, 1'b0, 2'd0, 16'h0000, 20'h25000, "R6 code unchanged");

    // R5: override
    doReq(2'd0, 1'b1, 2'd1, 16'h4321, 20'h16661, "R5 fetch override data");
    doReq(2'd2, 1'b1, 2'd2, 16'h0000, 20'h25670, "R5 source override stack");
    doReq(2'd1, 1'b1, 2'd3, 16'h0001, 20'h16651, "R5 stack override extra");

    // R3: wrap
    wrSeg(2'd3, 16'hFFFF);
    doReq(2'd3, 1'b0, 2'd0, 16'hFFFF, 20'h0FFEF, "R3 wrap FFFF:FFFF");
    doReq(2'd3, 1'b0, 2'd0, 16'h0010, calcAddr(16'hFFFF, 16'h0010), "R3 wrap to zero");
    // R6: other registers untouched by the extra write
    doReq(2'd2, 1'b0, 2'd0, 16'h0000, 20'h12340, "R6 data unchanged");
    doReq(2'd1, 1'b0, 2'd0, 16'h0000, 20'h25670, "R6 stack unchanged");

    // R7: write and request to the same register in one cycle
    wrSeg(2'd0, 16'h1111);
    wrEn = 1'b1; wrSel = 2'd0; wrData = 16'h2222;
    doReq(2'd0, 1'b0, 2'd0, 16'h0000, 20'h11110, "R7 old value seen");
    wrEn = 1'b0;
    doReq(2'd0, 1'b0, 2'd0, 16'h0000, 20'h22220, "R7 new value next");

    // R8: idle cycles keep the address and raise no valid
    @(negedge clk);
    held = physAddr;
    for (int i = 0; i < 3; i++) begin
      offset = 16'(16'hA5A5 + i);
      @(negedge clk);
      check("R8 hold physAddr", 32'(physAddr), 32'(held));
      check("R8 idle addrValid", 32'(addrValid), 32'h0);
    end
    check("R8 all results seen", 32'(expQ.size()), 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule